// File: doc/BRIEF.md
# Streaming Sliding-Window Median Filter

This block computes the median of the most recent `2K+1` samples of a one-dimensional data stream. Each accepted sample enters a linear chain of identical slots. The chain keeps the window sorted at all times, so the median is always held in the slot at the centre of the chain.

Each slot stores one sample value, an empty marker, and an age row of `W` bits. The age row is a thermometer code: its number of ones is the sample's age plus one, and a row of all ones marks the oldest entry. When a new sample arrives, every slot compares its stored value with the sample. Each slot then looks only at the results of its two neighbours and the eviction marker, and picks one of four moves: hold, load from above, load from below, or load the new sample. In a single clock this removes the oldest entry and inserts the new one in sorted position.

The block accepts one sample per clock. The median output is registered and carries a strobe, which first appears once a full window has been received.

Top module: `median_filter_core`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `out_median` is 0 until samples arrive.
- R2: `out_valid` is high in the cycle after an accepted sample if, and only if, at least `W = 2K+1` samples have been accepted since reset, counting that sample. It is never high in a cycle that follows a clock without `in_valid`.
- R3: Whenever `out_valid` is high, `out_median` equals the element of rank `K` (the middle one) of the last `W` accepted samples, compared as unsigned numbers.
- R4: The median that includes a given sample appears on `out_median` on the first rising clock edge at which that sample is accepted, with one register of latency.
- R5: A clock with `in_valid` low changes neither the window contents nor `out_median`, and `out_valid` is 0 after it.
- R6: Runs of equal values, and windows that hold duplicates, produce the correct median.
- R7: Each accepted sample, once the window is full, evicts exactly the oldest sample. Monotonic rising and falling runs therefore track the window.
- R8: Asserting reset in the middle of a stream discards the whole window. The next `W-1` accepted samples give no valid output, and the `W`-th one does.
- R9: Occupied slots hold values in non-increasing order from slot 0 downward, and empty slots sit above all occupied ones.
- R10: Sample width `DW` and half-window `K` are parameters. Values at both ends of the unsigned range (0 and `2^DW-1`) are handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted on this clock |
| in_sample | input | DW | Unsigned sample value |
| out_valid | output | 1 | Median strobe, registered |
| out_median | output | DW | Registered median of the current window |

## Verification
The bench builds the block with `DW = 8` and `K = 2`, a five-sample window. This is small enough that ties, eviction from every slot position and the move of the insert point from top to bottom of the chain all occur within short directed runs. An 8-bit width lets the bench drive both ends of the value range directly. A long pseudo-random stream with idle gaps then sets every eviction slot against every insert slot.

// File: rtl/median_pkg.sv
package median_pkg;

  // Move chosen by one slot on an accepted sample
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DN   = 2'd2,
    MV_IN   = 2'd3
  } move_e;

endpackage

// File: rtl/median_evict_scan.sv
// Marks every slot at or below the topmost slot whose age row is saturated.
module median_evict_scan #(
  parameter int W = 5
) (
  input  logic [W-1:0] oldest,
  output logic [W-1:0] gone_at
);

  always_comb begin
    gone_at[0] = oldest[0];
    for (int i = 1; i < W; i++) begin
      gone_at[i] = gone_at[i-1] | oldest[i];
    end
  end

endmodule

// File: rtl/median_cell.sv
module median_cell
  import median_pkg::*;
#(
  parameter int DW = 8,
  parameter int W  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] din,
  input  logic          flag_above,
  input  logic          flag_below,
  input  logic          gone_here,
  input  logic          gone_above,
  input  logic [DW-1:0] val_above,
  input  logic [W-1:0]  row_above,
  input  logic          empty_above,
  input  logic [DW-1:0] val_below,
  input  logic [W-1:0]  row_below,
  input  logic          empty_below,
  output logic [DW-1:0] val_q,
  output logic [W-1:0]  row_q,
  output logic          empty_q,
  output logic          flag,
  output logic          oldest,
  output logic [DW-1:0] val_nxt
);

  move_e         mv;
  logic [W-1:0]  row_nxt;
  logic          empty_nxt;
  logic [W-1:0]  row_src;

  always_comb begin
    flag   = !empty_q && (val_q < din);
    oldest = row_q[W-1];
  end

  // Local steering from neighbour flags and eviction position
  always_comb begin
    if (gone_here && !flag_below) begin
      mv = MV_DN;
    end else if ((gone_here && !flag && flag_below) ||
                 (!gone_above && flag && !flag_above)) begin
      mv = MV_IN;
    end else if (!gone_above && flag_above) begin
      mv = MV_UP;
    end else begin
      mv = MV_HOLD;
    end
  end

  always_comb begin
    val_nxt   = val_q;
    row_src   = row_q;
    empty_nxt = empty_q;
    unique case (mv)
      MV_UP: begin
        val_nxt   = val_above;
        row_src   = row_above;
        empty_nxt = empty_above;
      end
      MV_DN: begin
        val_nxt   = val_below;
        row_src   = row_below;
        empty_nxt = empty_below;
      end
      MV_IN: begin
        val_nxt   = din;
        row_src   = '0;
        empty_nxt = 1'b0;
      end
      default: ;
    endcase
    // every entry ages by one position per accepted sample
    row_nxt = {row_src[W-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      row_q   <= '1;
      empty_q <= 1'b1;
    end else if (accept) begin
      val_q   <= val_nxt;
      row_q   <= row_nxt;
      empty_q <= empty_nxt;
    end
  end

endmodule

// File: rtl/median_filter_core.sv
module median_filter_core #(
  parameter int DW = 8,
  parameter int K  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [DW-1:0] out_median
);

  localparam int W  = 2 * K + 1;
  localparam int CW = $clog2(W + 1);

  logic [W-1:0][DW-1:0] cell_val;
  logic [W-1:0][DW-1:0] cell_nxt;
  logic [W-1:0][W-1:0]  cell_row;
  logic [W-1:0]         cell_empty;
  logic [W-1:0]         cell_flag;
  logic [W-1:0]         cell_old;
  logic [W-1:0]         gone;
  logic [CW-1:0]        fill_q;

  median_evict_scan #(.W(W)) scan_i (
    .oldest  (cell_old),
    .gone_at (gone)
  );

  for (genvar i = 0; i < W; i++) begin : g_slot
    logic          fa, ga, ea;
    logic [DW-1:0] va;
    logic [W-1:0]  ra;
    logic          fb, eb;
    logic [DW-1:0] vb;
    logic [W-1:0]  rb;

    if (i == 0) begin : g_top
      assign fa = 1'b0;
      assign ga = 1'b0;
      assign va = '0;
      assign ra = '1;
      assign ea = 1'b1;
    end else begin : g_mid_a
      assign fa = cell_flag[i-1];
      assign ga = gone[i-1];
      assign va = cell_val[i-1];
      assign ra = cell_row[i-1];
      assign ea = cell_empty[i-1];
    end

    if (i == W - 1) begin : g_bot
      assign fb = 1'b1;
      assign vb = '0;
      assign rb = '1;
      assign eb = 1'b1;
    end else begin : g_mid_b
      assign fb = cell_flag[i+1];
      assign vb = cell_val[i+1];
      assign rb = cell_row[i+1];
      assign eb = cell_empty[i+1];
    end

    median_cell #(.DW(DW), .W(W)) cell_i (
      .clk         (clk),
      .rst         (rst),
      .accept      (in_valid),
      .din         (in_sample),
      .flag_above  (fa),
      .flag_below  (fb),
      .gone_here   (gone[i]),
      .gone_above  (ga),
      .val_above   (va),
      .row_above   (ra),
      .empty_above (ea),
      .val_below   (vb),
      .row_below   (rb),
      .empty_below (eb),
      .val_q       (cell_val[i]),
      .row_q       (cell_row[i]),
      .empty_q     (cell_empty[i]),
      .flag        (cell_flag[i]),
      .oldest      (cell_old[i]),
      .val_nxt     (cell_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q     <= '0;
      out_valid  <= 1'b0;
      out_median <= '0;
    end else begin
      out_valid <= in_valid && (fill_q >= CW'(W - 1));
      if (in_valid) begin
        out_median <= cell_nxt[K];
        if (fill_q < CW'(W)) fill_q <= fill_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/median_chk.sv
module median_chk #(
  parameter int DW = 8,
  parameter int W  = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [W-1:0][DW-1:0] cell_val,
  input logic [W-1:0]         cell_empty,
  input logic [W-1:0]         cell_old
);

  assert_valid_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_idle_keeps_window_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cell_val));

  assert_single_oldest_R7: assert property (@(posedge clk) disable iff (rst)
    (cell_empty == '0) |-> ($countones(cell_old) == 1));

  for (genvar i = 0; i < W - 1; i++) begin : g_pair
    assert_order_R9: assert property (@(posedge clk) disable iff (rst)
      (!cell_empty[i] && !cell_empty[i+1]) |-> (cell_val[i] >= cell_val[i+1]));
    assert_empty_top_R9: assert property (@(posedge clk) disable iff (rst)
      cell_empty[i+1] |-> cell_empty[i]);
  end

endmodule

bind median_filter_core median_chk #(.DW(DW), .W(W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .cell_val   (cell_val),
  .cell_empty (cell_empty),
  .cell_old   (cell_old)
);

// File: tb/median_filter_core_tb_top.sv
module median_filter_core_tb_top;

  localparam int DW = 8;
  localparam int K  = 2;
  localparam int W  = 2 * K + 1;
  localparam int NS = 24;

  localparam logic [7:0] STIM [NS] = '{
    8'd10, 8'd200, 8'd3,  8'd77, 8'd77, 8'd150, 8'd1,   8'd99,
    8'd99, 8'd98,  8'd0,  8'd255,8'd128,8'd64,  8'd32,  8'd16,
    8'd8,  8'd5,   8'd130,8'd130,8'd131,8'd129, 8'd255, 8'd0
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] in_sample;
  logic          out_valid;
  logic [DW-1:0] out_median;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] hist [W];
  int            seen;

  always #5 clk = ~clk;

  median_filter_core #(.DW(DW), .K(K)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_median (out_median)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_median();
    logic [DW-1:0] s [W];
    for (int i = 0; i < W; i++) s[i] = hist[i];
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W - 1 - i; j++) begin
        if (s[j] > s[j+1]) begin
          logic [DW-1:0] t = s[j];
          s[j] = s[j+1];
          s[j+1] = t;
        end
      end
    end
    return int'(s[K]);
  endfunction

  // sample driven at negedge, accepted at posedge, checked at next negedge
  task automatic push(input logic [DW-1:0] x, input string tag);
    in_sample = x;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = W - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    seen++;
    check({tag, " R2 valid"}, int'(out_valid), (seen >= W) ? 1 : 0);
    if (seen >= W) check({tag, " R3 R4 R9 median"}, int'(out_median), ref_median());
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    seen = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    logic [DW-1:0] held;
    in_sample = '0;
    do_reset();
    // R1 reset state
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset median", int'(out_median), 0);
    @(negedge clk);
    check("R1 idle after reset", int'(out_valid), 0);

    // table walk
    for (int n = 0; n < NS; n++) push(STIM[n], "table");

    // R5 idle cycles keep median, drop strobe
    held = out_median;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check("R5 idle valid", int'(out_valid), 0);
      check("R5 idle median", int'(out_median), int'(held));
    end
    push(8'd60, "R5 resume");

    // R6 equal runs
    for (int n = 0; n < 2 * W; n++) push(8'd42, "R6 equal");
    push(8'd42, "R6 equal");
    check("R6 equal median", int'(out_median), 42);

    // R7 monotonic runs
    for (int n = 0; n < 12; n++) push(8'(n * 20), "R7 rise");
    check("R7 rise median", int'(out_median), 180);
    for (int n = 11; n >= 0; n--) push(8'(n * 20 + 3), "R7 fall");
    check("R7 fall median", int'(out_median), 43);

    // R10 range extremes
    for (int n = 0; n < 9; n++) push((n % 2 == 0) ? 8'd255 : 8'd0, "R10 extremes");
    check("R10 extremes median", int'(out_median), 255);
    push(8'd0, "R10 extremes");
    check("R10 extremes median", int'(out_median), 0);

    // R8 reset mid-stream
    push(8'd7, "R8 pre");
    do_reset();
    check("R8 reset valid", int'(out_valid), 0);
    for (int n = 0; n < W - 1; n++) push(8'(100 - n), "R8 refill");
    push(8'd50, "R8 full");
    check("R8 first valid", int'(out_valid), 1);
    check("R8 first median", int'(out_median), 98);

    // pseudo-random stream with gaps
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) begin
        @(negedge clk);
        check("R5 gap valid", int'(out_valid), 0);
      end else begin
        push((lfsr[4]) ? {5'd0, lfsr[7:5]} : lfsr[15:8], "R3 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule